// File: doc/BRIEF.md
# Serial-Bus Gain Control Register Slave

This block is the digital control side of a differential audio gain stage. It is a two-wire serial (I2C) slave that runs from the system clock and oversamples the bus. It holds one 8-bit control word, and that word drives an analog amplifier outside the block. The slave picks up START, repeated START and STOP conditions on the bus. It answers a 7-bit device address whose upper four bits are fixed at binary 1010 and whose lower three bits come from board strap inputs. Up to eight of these slaves can therefore share one bus.

A write transfer has three parts: the device address, then a one-byte memory address, then one or more data bytes. The memory address is latched into a pointer that never advances. Reads return data from wherever that pointer was last left, so a random read is a dummy write of the memory address, then a repeated START, then the address byte with the read flag set.

Only memory address F8h holds the control word. Writes to other addresses, and writes that carry an illegal gain code, are acknowledged and then discarded. The outputs are the gain code, a standby flag and an effective mute flag, which is already combined with standby.

Top module: `gain_ctl_i2c_slave`

## Requirements
- R1: After reset the control word is 80h. This gives gain code 0, standby output 1, effective mute 1, and SDA released.
- R2: The slave answers only an address byte whose upper seven bits equal {1010, strap[2], strap[1], strap[0]}, with the read/write flag in bit 0 (1 = read). If the address byte does not match, the slave gives no ACK and ignores everything up to the next START or repeated START.
- R3: Bytes go MSB first, and SDA is sampled on the rising SCL edge. In a write, the slave pulls SDA low in the ninth (ACK) slot of the address byte, the memory-address byte and every data byte.
- R4: A data byte is stored only when the pointer equals F8h. Data written at any other address is ACKed and leaves the outputs unchanged.
- R5: A data byte whose bits 4:0 exceed 14h leaves the whole control word unchanged but is still ACKed. Gain codes 00h to 14h are stored.
- R6: Control word layout: bit 7 is standby, bit 6 is stored but has no effect on the outputs, bit 5 is mute, and bits 4:0 are the gain code, which drives the gain output.
- R7: The effective mute output is high when either mute or standby is set. The standby output follows bit 7.
- R8: A read returns the control word when the pointer is F8h and FFh otherwise. The pointer holds the last memory-address byte and does not advance, so consecutive read bytes are identical.
- R9: The slave changes its SDA drive only after a falling SCL edge (or a bus condition). It releases SDA after the master NACKs a read byte.
- R10: The pointer resets to F8h, so a read issued straight after reset returns the control word without a dummy write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad (wired-AND value) |
| strap_i | input | 3 | Board straps forming the low three address bits, strap_i[2] most significant |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| gain_code_o | output | 5 | Stored gain code for the amplifier |
| mute_eff_o | output | 1 | Amplifier output silenced (mute or standby) |
| standby_o | output | 1 | Amplifier in low-power standby |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer, fixed address nibble 1010, register location F8h and a largest legal gain code of 14h. With these values every strap combination can be swept, with matching and mismatching address bytes, and all 32 gain codes can be written so that the legal/illegal boundary at 14h/15h is hit exactly. Each result is checked against a byte model kept in the bench, together with reads through both the retained pointer and a foreign pointer.

// File: rtl/gcr_pkg.sv
package gcr_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_MADDR,
    ST_MADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } bus_st_e;

  // Device address: fixed upper nibble followed by the straps
  function automatic logic [6:0] dev_addr(input logic [3:0] hi, input logic [2:0] strap);
    return {hi, strap};
  endfunction

  // A gain code is legal when it does not exceed the top code
  function automatic logic gain_ok(input logic [4:0] code, input logic [4:0] max_code);
    return code <= max_code;
  endfunction

  // Effective silence: either explicit mute or standby
  function automatic logic silence(input logic mute, input logic stby);
    return mute | stby;
  endfunction

endpackage

// File: rtl/gcr_bus_sync.sv
module gcr_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] scl_pipe, sda_pipe;
  logic          scl_d, sda_d;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[LAST-1:0], scl_i};
          sda_pipe <= {sda_pipe[LAST-1:0], sda_i};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_pipe[LAST];
      sda_d <= sda_pipe[LAST];
    end
  end

  assign scl_s     = scl_pipe[LAST];
  assign sda_s     = sda_pipe[LAST];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/gcr_proto.sv
module gcr_proto
  import gcr_pkg::*;
#(
  parameter logic [3:0] ADDR_HI = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [2:0] strap,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       ptr_load,
  output logic       wr_pulse,
  output logic [7:0] rx_byte,
  output logic       ignoring
);
  bus_st_e    st_q;
  logic [7:0] rx_q, tx_q;
  logic [2:0] bit_q;
  logic       full_q, rw_q, mack_q, oe_q;
  logic       ptr_load_q, wr_pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      rx_q       <= '0;
      tx_q       <= '0;
      bit_q      <= '0;
      full_q     <= 1'b0;
      rw_q       <= 1'b0;
      mack_q     <= 1'b0;
      oe_q       <= 1'b0;
      ptr_load_q <= 1'b0;
      wr_pulse_q <= 1'b0;
    end else begin
      ptr_load_q <= 1'b0;
      wr_pulse_q <= 1'b0;
      if (start_det) begin
        st_q   <= ST_ADDR;
        bit_q  <= '0;
        full_q <= 1'b0;
        oe_q   <= 1'b0;
      end else if (stop_det) begin
        st_q   <= ST_IDLE;
        full_q <= 1'b0;
        oe_q   <= 1'b0;
      end else begin
        case (st_q)
          ST_ADDR, ST_MADDR, ST_WDATA: begin
            if (scl_rise && !full_q) begin
              rx_q  <= {rx_q[6:0], sda_s};
              bit_q <= bit_q + 3'd1;
              if (bit_q == 3'd7) full_q <= 1'b1;
            end else if (scl_fall && full_q) begin
              full_q <= 1'b0;
              if (st_q == ST_ADDR) begin
                if (rx_q[7:1] == dev_addr(ADDR_HI, strap)) begin
                  rw_q <= rx_q[0];
                  oe_q <= 1'b1;
                  st_q <= ST_ADDR_ACK;
                end else begin
                  st_q <= ST_IGNORE;
                end
              end else if (st_q == ST_MADDR) begin
                ptr_load_q <= 1'b1;
                oe_q       <= 1'b1;
                st_q       <= ST_MADDR_ACK;
              end else begin
                wr_pulse_q <= 1'b1;
                oe_q       <= 1'b1;
                st_q       <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bit_q <= '0;
              if (rw_q) begin
                tx_q <= rd_data;
                oe_q <= ~rd_data[7];
                st_q <= ST_RDATA;
              end else begin
                oe_q <= 1'b0;
                st_q <= ST_MADDR;
              end
            end
          end
          ST_MADDR_ACK, ST_WDATA_ACK: begin
            if (scl_fall) begin
              oe_q  <= 1'b0;
              bit_q <= '0;
              st_q  <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              bit_q <= bit_q + 3'd1;
              if (bit_q == 3'd7) begin
                oe_q   <= 1'b0;
                mack_q <= 1'b0;
                st_q   <= ST_RACK;
              end else begin
                tx_q <= {tx_q[6:0], 1'b0};
                oe_q <= ~tx_q[6];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_s;
            end else if (scl_fall) begin
              if (mack_q) begin
                tx_q  <= rd_data;
                oe_q  <= ~rd_data[7];
                bit_q <= '0;
                st_q  <= ST_RDATA;
              end else begin
                st_q <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe   = oe_q;
  assign ptr_load = ptr_load_q;
  assign wr_pulse = wr_pulse_q;
  assign rx_byte  = rx_q;
  assign ignoring = (st_q == ST_IGNORE);

endmodule

// File: rtl/gcr_ctrl_reg.sv
module gcr_ctrl_reg
  import gcr_pkg::*;
#(
  parameter logic [7:0] REG_ADDR  = 8'hF8,
  parameter logic [7:0] RESET_VAL = 8'h80,
  parameter logic [4:0] MAX_GAIN  = 5'h14,
  parameter int         GAIN_W    = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ptr_load,
  input  logic       wr_pulse,
  input  logic [7:0] byte_i,
  output logic [7:0] ctrl_q,
  output logic [7:0] rd_data,
  output logic       wr_accept
);
  logic [7:0] ptr_q;
  logic       at_reg;

  assign at_reg    = (ptr_q == REG_ADDR);
  assign wr_accept = wr_pulse & at_reg & gain_ok(byte_i[GAIN_W-1:0], MAX_GAIN);
  assign rd_data   = at_reg ? ctrl_q : 8'hFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= REG_ADDR;
      ctrl_q <= RESET_VAL;
    end else begin
      if (ptr_load)  ptr_q  <= byte_i;
      if (wr_accept) ctrl_q <= byte_i;
    end
  end

endmodule

// File: rtl/gain_ctl_i2c_slave.sv
module gain_ctl_i2c_slave
  import gcr_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] ADDR_HI     = 4'b1010,
  parameter logic [7:0] REG_ADDR    = 8'hF8,
  parameter logic [7:0] RESET_VAL   = 8'h80,
  parameter logic [4:0] MAX_GAIN    = 5'h14,
  parameter int         GAIN_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  output logic              sda_oe_o,
  output logic [GAIN_W-1:0] gain_code_o,
  output logic              mute_eff_o,
  output logic              standby_o
);
  localparam int STBY_BIT = 7;
  localparam int MUTE_BIT = 5;

  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       ptr_load, wr_pulse, wr_accept, ignoring;
  logic [7:0] rx_byte, ctrl_q, rd_data;

  gcr_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  gcr_proto #(.ADDR_HI(ADDR_HI)) u_proto (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .strap(strap_i), .rd_data(rd_data), .sda_oe(sda_oe_o),
    .ptr_load(ptr_load), .wr_pulse(wr_pulse), .rx_byte(rx_byte),
    .ignoring(ignoring)
  );

  gcr_ctrl_reg #(
    .REG_ADDR(REG_ADDR), .RESET_VAL(RESET_VAL),
    .MAX_GAIN(MAX_GAIN), .GAIN_W(GAIN_W)
  ) u_reg (
    .clk(clk), .rst_n(rst_n), .ptr_load(ptr_load), .wr_pulse(wr_pulse),
    .byte_i(rx_byte), .ctrl_q(ctrl_q), .rd_data(rd_data),
    .wr_accept(wr_accept)
  );

  assign gain_code_o = ctrl_q[GAIN_W-1:0];
  assign standby_o   = ctrl_q[STBY_BIT];
  assign mute_eff_o  = silence(ctrl_q[MUTE_BIT], ctrl_q[STBY_BIT]);

endmodule

// File: rtl/gcr_checker.sv
module gcr_checker #(
  parameter logic [4:0] MAX_GAIN = 5'h14
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       scl_fall,
  input logic       start_det,
  input logic       stop_det,
  input logic       sda_oe,
  input logic       ignoring,
  input logic       wr_accept,
  input logic [4:0] gain,
  input logic       mute_eff,
  input logic       standby
);
  // R9: drive changes only follow a falling SCL edge or a bus condition
  p_oe_after_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

  // R9: a drive change never coincides with SCL high unless caused by a bus condition
  p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_oe != $past(sda_oe)) && !$past(start_det) && !$past(stop_det)) |-> !$past(scl_s));

  // R2: an unaddressed slave keeps SDA released
  p_ignore_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ignoring |-> !sda_oe);

  // R7: standby always silences the output
  p_standby_mutes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> mute_eff);

  // R5: the stored gain code never leaves the legal range
  p_gain_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gain <= MAX_GAIN);

  // R4: outputs only move after an accepted write
  p_write_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((gain != $past(gain)) || (standby != $past(standby)) || (mute_eff != $past(mute_eff)))
      |-> $past(wr_accept));
endmodule

bind gain_ctl_i2c_slave gcr_checker #(.MAX_GAIN(MAX_GAIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det), .sda_oe(sda_oe_o),
  .ignoring(ignoring), .wr_accept(wr_accept), .gain(gain_code_o),
  .mute_eff(mute_eff_o), .standby(standby_o)
);

// File: tb/gain_ctl_i2c_slave_bench.sv
module gain_ctl_i2c_slave_bench;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       m_sda = 1'b1;
  logic [2:0] strap = 3'd0;
  logic       sda_oe;
  logic [4:0] gain;
  logic       mute_eff, standby;
  wire        sda_line = m_sda & ~sda_oe;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [7:0] exp_reg = 8'h80;
  logic [7:0] exp_ptr = 8'hF8;

  always #5 clk = ~clk;

  gain_ctl_i2c_slave u_gain_ctl_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .strap_i(strap),
    .sda_oe_o(sda_oe), .gain_code_o(gain), .mute_eff_o(mute_eff), .standby_o(standby)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      nfail = nfail + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk = nchk + 1;
    if (act !== exp) begin
      nfail = nfail + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    m_sda = 1'b0; tick(Q);
    scl = 1'b0;   tick(2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(Q);
      scl = 1'b1;   tick(Q);
      scl = 1'b0;   tick(2);
    end
    m_sda = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q/2);
    ack = ~sda_line; tick(Q/2);
    scl = 1'b0;   tick(2);
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; tick(Q);
      scl = 1'b1;   tick(Q/2);
      d[i] = sda_line; tick(Q/2);
      scl = 1'b0;   tick(2);
    end
    m_sda = ~give_ack; tick(Q);
    scl = 1'b1; tick(Q);
    scl = 1'b0; tick(2);
  endtask

  function automatic logic [7:0] addr_byte(input logic [2:0] s, input logic rd);
    return {4'b1010, s, rd};
  endfunction

  // Bench model of a three-byte write
  function automatic void model_write(input logic [7:0] maddr, input logic [7:0] d);
    exp_ptr = maddr;
    if (maddr == 8'hF8 && d[4:0] <= 5'd20) exp_reg = d;
  endfunction

  task automatic do_write(input logic [7:0] maddr, input logic [7:0] d, input string req);
    logic a0, a1, a2;
    bus_start();
    wbyte(addr_byte(strap, 1'b0), a0);
    wbyte(maddr, a1);
    wbyte(d, a2);
    bus_stop();
    tick(4);
    model_write(maddr, d);
    chk({req, " R3 write acks"}, {29'd0, a0, a1, a2}, 32'd7);
  endtask

  task automatic check_outputs(input string req);
    chk({req, " gain"}, {27'd0, gain}, {27'd0, exp_reg[4:0]});
    chk({req, " standby R7"}, {31'd0, standby}, {31'd0, exp_reg[7]});
    chk({req, " mute_eff R7"}, {31'd0, mute_eff}, {31'd0, exp_reg[5] | exp_reg[7]});
  endtask

  function automatic logic [7:0] exp_read();
    return (exp_ptr == 8'hF8) ? exp_reg : 8'hFF;
  endfunction

  initial begin
    logic a0, a1, a2;
    logic [7:0] d0, d1;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R1: reset state
    chk("R1 gain", {27'd0, gain}, 32'd0);
    chk("R1 standby", {31'd0, standby}, 32'd1);
    chk("R1 mute_eff", {31'd0, mute_eff}, 32'd1);
    chk("R1 sda released", {31'd0, sda_oe}, 32'd0);

    // R10: current-pointer read right after reset
    bus_start();
    wbyte(addr_byte(strap, 1'b1), a0);
    rbyte(1'b0, d0);
    tick(4);
    chk("R9 released after NACK", {31'd0, sda_oe}, 32'd0);
    bus_stop();
    chk("R10 read ack", {31'd0, a0}, 32'd1);
    chk("R10 read after reset", {24'd0, d0}, 32'h80);

    // R2: sweep all straps, matching and mismatching addresses
    for (int s = 0; s < 8; s++) begin
      strap = s[2:0];
      tick(4);
      do_write(8'hF8, {3'b000, 2'b00, s[2:0]}, "R2 strap");
      check_outputs("R2 strap");
      bus_start();
      wbyte(addr_byte(strap ^ 3'b101, 1'b0), a0);
      wbyte(8'hF8, a1);
      wbyte(8'h0C, a2);
      bus_stop();
      tick(4);
      chk("R2 mismatch no ack", {29'd0, a0, a1, a2}, 32'd0);
      check_outputs("R2 mismatch ignored");
    end

    // R2: ignored transfer resumes at repeated START
    bus_start();
    wbyte(addr_byte(strap ^ 3'b010, 1'b0), a0);
    wbyte(8'h10, a1);
    bus_start();
    wbyte(addr_byte(strap, 1'b1), a2);
    rbyte(1'b0, d0);
    bus_stop();
    chk("R2 repeated start acks", {29'd0, a0, a1, a2}, 32'd1);
    chk("R2 read after repeated start R8", {24'd0, d0}, {24'd0, exp_read()});

    // R5: sweep all 32 gain codes
    for (int c = 0; c < 32; c++) begin
      do_write(8'hF8, {3'b000, c[4:0]}, "R5 sweep");
      check_outputs("R5 sweep");
    end

    // R6 / R7: field layout
    do_write(8'hF8, 8'h25, "R6 mute");
    check_outputs("R6 mute");
    do_write(8'hF8, 8'hA7, "R6 standby");
    check_outputs("R6 standby");
    do_write(8'hF8, 8'h4B, "R6 bit6");
    check_outputs("R6 bit6");

    // R4: foreign address write acked and dropped, then R8 pointer reads
    do_write(8'h10, 8'h0A, "R4 foreign");
    check_outputs("R4 foreign");
    bus_start();
    wbyte(addr_byte(strap, 1'b1), a0);
    rbyte(1'b0, d0);
    bus_stop();
    chk("R8 foreign pointer read", {24'd0, d0}, 32'hFF);

    // R8: random read with two bytes, pointer does not advance
    bus_start();
    wbyte(addr_byte(strap, 1'b0), a0);
    wbyte(8'hF8, a1);
    exp_ptr = 8'hF8;
    bus_start();
    wbyte(addr_byte(strap, 1'b1), a2);
    rbyte(1'b1, d0);
    rbyte(1'b0, d1);
    tick(4);
    chk("R9 released after final NACK", {31'd0, sda_oe}, 32'd0);
    bus_stop();
    chk("R8 random read acks", {29'd0, a0, a1, a2}, 32'd7);
    chk("R8 first byte", {24'd0, d0}, {24'd0, exp_reg});
    chk("R8 second byte same", {24'd0, d1}, {24'd0, exp_reg});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule